// File: doc/BRIEF.md
# Watchdog Timer with Ordered Service Sequence

This block guards a processor against software that gets stuck. Once software sets the enable bit, a counter advances on every clock, or on every 8192nd clock when the prescaler is on. The counter restarts only when software writes a two-value key pair to the service register: 0x55 first, then 0xAA. Other bus traffic may come between the two writes, including other writes to the service register. If the counter reaches the selected terminal count before the pair completes, the block does one of two things, as a mode bit chooses. It either issues a one-cycle hardware reset request, sets a sticky flag and drives a reset-out pulse 32 clocks long, or it raises a level-7 interrupt request that carries a software-programmed 8-bit vector.

Two state machines carry the behaviour. The service tracker has the states SVC_IDLE and SVC_ARMED. Its transitions are *arm*, when 0x55 is written in either state, and *fire*, when 0xAA is written in SVC_ARMED. Fire emits the restart and returns the tracker to SVC_IDLE. In SVC_ARMED, any other write keeps the tracker armed. The action machine has the states ACT_IDLE, ACT_IRQ and ACT_RST. Its transitions are *timeout-irq* (ACT_IDLE to ACT_IRQ), *timeout-reset* (ACT_IDLE or ACT_IRQ to ACT_RST), *serviced* (ACT_IRQ to ACT_IDLE) and *pulse-done* (ACT_RST to ACT_IDLE after 32 cycles).

The register bus is a plain select/write/address strobe with combinational read data. Address 0 holds control, 1 the vector, 2 the service register (reads as 0) and 3 the status register.

Top module: `wdt_top`

## Requirements
- R1: After the asynchronous active-low reset, every output is 0 and the control, vector and status registers read 0.
- R2: With control bit 7 (enable) clear, the counter stays at zero and no timeout occurs, however long the wait.
- R3: Control bits 4:3 select the terminal count: 0, 1, 2 and 3 give 512, 2048, 8192 and 32768 counts. With the prescaler off, the timeout action becomes visible exactly that many clock edges after the edge that writes enable, or after the edge of the completing service write.
- R4: With control bit 5 (prescaler) set, the counter advances only once per 8192 clocks, so no timeout occurs within 3000 clocks at terminal count 512.
- R5: Writing 0x55 and later 0xAA to the service register (address 2) restarts the count from zero on the edge of the 0xAA write.
- R6: Between the 0x55 and 0xAA writes, writes of other values to the service register, repeated 0x55 writes and writes to other registers leave the sequence armed.
- R7: A 0xAA write to the service register while no 0x55 is armed has no effect: the count is not restarted and a pending interrupt stays pending.
- R8: With control bit 6 set (interrupt mode), a timeout asserts the interrupt request with level output 7 and the vector register's value. The request stays asserted until a completed service sequence clears it.
- R9: With control bit 6 clear (reset mode), a timeout asserts the reset request for exactly one cycle and sets status bit 0. The control register keeps its value.
- R10: On a reset-mode timeout, the reset-out output is high for exactly 32 consecutive cycles when control bit 0 (reset-out select) is set, and stays low when it is clear.
- R11: Status bit 0 is cleared by writing 1 to it. Writing 0 leaves it set.
- R12: The vector register (address 1) holds any 8-bit value written to it, reads it back, and presents it on the vector output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 vector, 2 service, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, 0 when not selected) |
| wd_rst_req | output | 1 | One-cycle hardware reset request |
| wd_rst_out | output | 1 | Reset-out pin drive, 32-cycle pulse |
| wd_irq | output | 1 | Watchdog interrupt request |
| wd_irq_level | output | 3 | Interrupt priority level, 7 while requesting, else 0 |
| wd_irq_vec | output | 8 | Interrupt vector |

## Verification
The hardest case to reach is a service sequence broken up by other traffic that completes just before a timeout. Here the restart has to move the timeout deadline. The stimulus lets the counter run to 400 of 512 counts. It then writes 0x55, a foreign service value, a repeated 0x55, a vector write and a rewrite of control before the closing 0xAA. It then checks that nothing happens at the original deadline and that the timeout lands exactly 512 edges after the 0xAA edge. An unarmed 0xAA is placed mid-count and again while an interrupt is pending, to show that neither the deadline nor the request moves.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_VECTOR = 2'd1;
    localparam logic [ADDR_W-1:0] A_SVC    = 2'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

    localparam logic [DATA_W-1:0] KEY_ARM  = 8'h55;
    localparam logic [DATA_W-1:0] KEY_FIRE = 8'hAA;

    localparam logic [2:0] IRQ_LEVEL_TOP = 3'd7;

    typedef enum logic {
        SVC_IDLE,
        SVC_ARMED
    } svc_state_t;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_IRQ,
        ACT_RST
    } act_state_t;

    typedef struct packed {
        logic       enable;
        logic       irq_mode;
        logic       presc;
        logic [1:0] tsel;
        logic [1:0] unused;
        logic       pin_sel;
    } ctrl_t;

endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
    parameter int PRESC_DIV   = 8192,
    parameter int TC_LOG2_MIN = 9,
    parameter int TC_LOG2_STP = 2,
    parameter int TSEL_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              presc,
    input  logic [TSEL_W-1:0] tsel,
    input  logic              clear,
    output logic              expire
);
    localparam int CNT_W = TC_LOG2_MIN + TC_LOG2_STP * ((1 << TSEL_W) - 1);

    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term_m1;
    logic [CNT_W:0]   term;

    generate
        if (PRESC_DIV > 1) begin : g_presc
            localparam int PW = $clog2(PRESC_DIV);
            localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);
            logic [PW-1:0] pre_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_cnt <= '0;
                end else if (!en || clear || !presc || pre_cnt == LAST) begin
                    pre_cnt <= '0;
                end else begin
                    pre_cnt <= pre_cnt + 1'b1;
                end
            end

            assign tick = !presc || (pre_cnt == LAST);

            p_presc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (en && presc && !clear && pre_cnt != LAST) |=> $stable(cnt));
        end else begin : g_nopresc
            assign tick = 1'b1;
        end
    endgenerate

    always_comb begin
        term    = (CNT_W + 1)'(1) << (TC_LOG2_MIN + TC_LOG2_STP * int'(tsel));
        term_m1 = CNT_W'(term - 1'b1);
    end

    assign expire = en && !clear && tick && (cnt == term_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || clear || expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

endmodule

// File: rtl/wdt_service.sv
module wdt_service
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_svc,
    input  logic [DATA_W-1:0] wdata,
    output logic              done
);
    svc_state_t st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= SVC_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            SVC_IDLE: begin
                if (wr_svc && wdata == KEY_ARM) st_nxt = SVC_ARMED;
            end
            SVC_ARMED: begin
                if (wr_svc && wdata == KEY_FIRE) st_nxt = SVC_IDLE;
            end
            default: st_nxt = SVC_IDLE;
        endcase
    end

    always_comb begin
        done = 1'b0;
        unique case (st)
            SVC_IDLE:  done = 1'b0;
            SVC_ARMED: done = wr_svc && (wdata == KEY_FIRE);
            default:   done = 1'b0;
        endcase
    end

    p_unarmed_fire_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SVC_IDLE && wr_svc && wdata == KEY_FIRE) |=> (st == SVC_IDLE));

    p_armed_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SVC_ARMED && !(wr_svc && wdata == KEY_FIRE)) |=> (st == SVC_ARMED));

endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic irq_mode,
    input  logic pin_sel,
    input  logic svc_done,
    output logic irq,
    output logic rst_req,
    output logic rst_out,
    output logic rst_start
);
    localparam int PCW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PCW-1:0] P_LAST = PCW'(PULSE_LEN - 1);

    act_state_t       st, st_nxt;
    logic [PCW-1:0]   pcnt;
    logic             pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ACT_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ACT_IDLE: begin
                if (expire && !irq_mode)     st_nxt = ACT_RST;
                else if (expire && irq_mode) st_nxt = ACT_IRQ;
            end
            ACT_IRQ: begin
                if (expire && !irq_mode)     st_nxt = ACT_RST;
                else if (svc_done)           st_nxt = ACT_IDLE;
            end
            ACT_RST: begin
                if (pcnt == P_LAST)          st_nxt = ACT_IDLE;
            end
            default: st_nxt = ACT_IDLE;
        endcase
    end

    assign rst_start = (st_nxt == ACT_RST) && (st != ACT_RST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt  <= '0;
            pin_q <= 1'b0;
        end else if (rst_start) begin
            pcnt  <= '0;
            pin_q <= pin_sel;
        end else if (st == ACT_RST) begin
            pcnt  <= pcnt + 1'b1;
        end
    end

    always_comb begin
        irq     = 1'b0;
        rst_req = 1'b0;
        rst_out = 1'b0;
        unique case (st)
            ACT_IDLE: ;
            ACT_IRQ:  irq = 1'b1;
            ACT_RST: begin
                rst_req = (pcnt == '0);
                rst_out = pin_q;
            end
            default: ;
        endcase
    end

    p_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !svc_done && !expire) |=> irq);

    p_rst_req_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_rst_out_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out && pcnt != P_LAST) |=> rst_out);

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int PRESC_DIV   = 8192,
    parameter int TC_LOG2_MIN = 9,
    parameter int TC_LOG2_STP = 2,
    parameter int PULSE_LEN   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_rst_req,
    output logic              wd_rst_out,
    output logic              wd_irq,
    output logic [2:0]        wd_irq_level,
    output logic [DATA_W-1:0] wd_irq_vec
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] vec;
    logic              wd_flag;
    logic              wr_ctrl, wr_vec, wr_svc, wr_stat;
    logic              expire, svc_done, rst_start;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
    assign wr_vec  = bus_sel && bus_wr && (bus_addr == A_VECTOR);
    assign wr_svc  = bus_sel && bus_wr && (bus_addr == A_SVC);
    assign wr_stat = bus_sel && bus_wr && (bus_addr == A_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
            vec  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl        <= ctrl_t'(bus_wdata);
                ctrl.unused <= '0;
            end
            if (wr_vec) vec <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_flag <= 1'b0;
        end else if (rst_start) begin
            wd_flag <= 1'b1;
        end else if (wr_stat && bus_wdata[0]) begin
            wd_flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                A_CTRL:   bus_rdata = DATA_W'(ctrl);
                A_VECTOR: bus_rdata = vec;
                A_SVC:    bus_rdata = '0;
                A_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, wd_flag};
                default:  bus_rdata = '0;
            endcase
        end
    end

    wdt_timebase #(
        .PRESC_DIV  (PRESC_DIV),
        .TC_LOG2_MIN(TC_LOG2_MIN),
        .TC_LOG2_STP(TC_LOG2_STP),
        .TSEL_W     (2)
    ) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl.enable),
        .presc (ctrl.presc),
        .tsel  (ctrl.tsel),
        .clear (svc_done),
        .expire(expire)
    );

    wdt_service u_service (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_svc(wr_svc),
        .wdata (bus_wdata),
        .done  (svc_done)
    );

    wdt_action #(
        .PULSE_LEN(PULSE_LEN)
    ) u_action (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .irq_mode (ctrl.irq_mode),
        .pin_sel  (ctrl.pin_sel),
        .svc_done (svc_done),
        .irq      (wd_irq),
        .rst_req  (wd_rst_req),
        .rst_out  (wd_rst_out),
        .rst_start(rst_start)
    );

    assign wd_irq_level = wd_irq ? IRQ_LEVEL_TOP : 3'd0;
    assign wd_irq_vec   = vec;

    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> wd_flag);

    p_ctrl_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_start && !wr_ctrl) |=> $stable(ctrl));

    p_vec_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_irq && !wr_vec) |=> $stable(wd_irq_vec));

    p_modes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wd_irq && wd_rst_out));

endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wd_rst_req, wd_rst_out, wd_irq;
    logic [2:0] wd_irq_level;
    logic [7:0] wd_irq_vec;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_top dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_rst_req(wd_rst_req), .wd_rst_out(wd_rst_out), .wd_irq(wd_irq),
        .wd_irq_level(wd_irq_level), .wd_irq_vec(wd_irq_vec)
    );

    // tsel[20:19], irq_mode[18], pin_sel[17], period[16:0]
    localparam logic [20:0] TBL [0:3] = '{
        {2'd0, 1'b1, 1'b0, 17'd512},
        {2'd1, 1'b1, 1'b1, 17'd2048},
        {2'd2, 1'b0, 1'b1, 17'd8192},
        {2'd3, 1'b0, 1'b0, 17'd32768}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int t0, t1, n;
        do_reset();

        // R1: reset state
        chk("R1 irq", wd_irq, 0);
        chk("R1 rst_req", wd_rst_req, 0);
        chk("R1 rst_out", wd_rst_out, 0);
        chk("R1 level", wd_irq_level, 0);
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd1, d); chk("R1 vector", d, 0);
        rd(2'd3, d); chk("R1 status", d, 0);

        // R3 R8 R9 R10: table of timeout periods and actions
        for (int i = 0; i < 4; i++) begin
            logic [7:0] cv;
            do_reset();
            cv = {1'b1, TBL[i][18], 1'b0, TBL[i][20:19], 2'b00, TBL[i][17]};
            wr(2'd0, cv);
            t0 = cyc;
            wait_until(t0 + int'(TBL[i][16:0]) - 1);
            chk("R3 early", {wd_irq, wd_rst_req, wd_rst_out}, 0);
            wait_until(t0 + int'(TBL[i][16:0]));
            if (TBL[i][18]) begin
                chk("R3 R8 irq", wd_irq, 1);
                chk("R8 level", wd_irq_level, 7);
                chk("R8 no reset", wd_rst_req, 0);
            end else begin
                chk("R3 R9 rst_req", wd_rst_req, 1);
                n = 0;
                for (int k = 0; k < 40; k++) begin
                    if (wd_rst_out) n++;
                    @(negedge clk);
                    if (k == 0) chk("R9 single", wd_rst_req, 0);
                end
                chk("R10 pulse length", n, TBL[i][17] ? 32 : 0);
                chk("R9 no irq", wd_irq, 0);
                rd(2'd3, d); chk("R9 status", d, 1);
                rd(2'd0, d); chk("R9 ctrl kept", d, cv);
            end
        end

        // R12: vector register
        do_reset();
        wr(2'd1, 8'hC3);
        rd(2'd1, d); chk("R12 readback", d, 8'hC3);
        chk("R12 output", wd_irq_vec, 8'hC3);

        // R2: disabled
        wr(2'd0, 8'h40);
        repeat (1000) @(negedge clk);
        chk("R2 disabled", wd_irq, 0);

        // R4: prescaler
        wr(2'd0, 8'hE0);
        repeat (3000) @(negedge clk);
        chk("R4 prescaled", wd_irq, 0);

        // R5 R6: split sequence near deadline
        do_reset();
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'hC0);
        t0 = cyc;
        wait_until(t0 + 400);
        wr(2'd2, 8'h55);
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h55);
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'hC0);
        wr(2'd2, 8'hAA);
        t1 = cyc;
        wait_until(t0 + 512);
        chk("R5 R6 old deadline", wd_irq, 0);
        wait_until(t1 + 511);
        chk("R5 before", wd_irq, 0);
        wait_until(t1 + 512);
        chk("R5 restart", wd_irq, 1);
        chk("R8 vector", wd_irq_vec, 8'h5A);

        // R8 R7: pending request held, unarmed AA ignored
        repeat (100) @(negedge clk);
        chk("R8 held", wd_irq, 1);
        wr(2'd2, 8'hAA);
        chk("R7 pending kept", wd_irq, 1);
        wr(2'd2, 8'h55);
        wr(2'd2, 8'hAA);
        t1 = cyc;
        chk("R8 cleared", wd_irq, 0);

        // R7: unarmed AA does not restart
        wait_until(t1 + 300);
        wr(2'd2, 8'hAA);
        wait_until(t1 + 511);
        chk("R7 before", wd_irq, 0);
        wait_until(t1 + 512);
        chk("R7 no restart", wd_irq, 1);

        // R11: status clear
        do_reset();
        wr(2'd0, 8'h80);
        repeat (520) @(negedge clk);
        rd(2'd3, d); chk("R11 set", d, 1);
        chk("R10 pin off", wd_rst_out, 0);
        wr(2'd3, 8'h00);
        rd(2'd3, d); chk("R11 write0 keeps", d, 1);
        wr(2'd3, 8'h01);
        rd(2'd3, d); chk("R11 write1 clears", d, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule